// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block produces every control signal needed by a single-cycle datapath that runs a small load/store, register-arithmetic and branch-on-equal instruction set. Decoding takes place in two stages. The first stage reads only the 6-bit primary opcode. From it, the stage produces the datapath steering and enable signals and a 2-bit operation class. The second stage combines that class with the 6-bit function field of register-format instructions and selects a 3-bit ALU operation.

The decode logic itself is combinational. To suit an FPGA pipeline, every output is captured in a register with a synchronous active-high reset. The outputs therefore show the decode of the opcode and function field that were sampled at the previous rising clock edge. If an opcode is not recognised, the block drops every register-file, memory and branch enable, so that such an instruction leaves the processor state unchanged.

Top module: `sc_ctl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes 0 on that edge, whatever the opcode and function inputs are.
- R2: The outputs change only on a rising edge. They carry the decode of `op_i`/`fn_i` as sampled at that edge, which gives one cycle of latency.
- R3: Opcode 0 (register format) gives `dst_rd_o`=1, `rf_we_o`=1, `src_imm_o`=0, `wb_mem_o`=0, `mem_re_o`=0, `mem_we_o`=0, `br_o`=0 and `cls_o`=2'b10.
- R4: Opcode 35 (load word) gives `src_imm_o`=1, `wb_mem_o`=1, `rf_we_o`=1 and `mem_re_o`=1, with `dst_rd_o`, `mem_we_o` and `br_o` at 0 and `cls_o`=2'b00.
- R5: Opcode 43 (store word) gives `src_imm_o`=1 and `mem_we_o`=1, with `rf_we_o`, `mem_re_o`, `wb_mem_o`, `dst_rd_o` and `br_o` at 0 and `cls_o`=2'b00.
- R6: Opcode 4 (branch if equal) gives `br_o`=1 and `cls_o`=2'b01, with every other single-bit output at 0.
- R7: When the class is 2'b00 (memory), `alu_op_o` is 3'b010 (add) for any function field.
- R8: When the class is 2'b01 (compare), `alu_op_o` is 3'b110 (subtract) for any function field.
- R9: In register format the function field selects the ALU code: 0x20 gives 3'b010 (add), 0x22 gives 3'b110 (subtract), 0x24 gives 3'b000 (AND), 0x25 gives 3'b001 (OR) and 0x2A gives 3'b111 (set-on-less-than).
- R10: In register format, any other function value gives `alu_op_o`=3'b010. The register write stays enabled.
- R11: Any opcode other than 0, 4, 35 and 43 gives every single-bit output 0, `cls_o`=2'b00 and `alu_op_o`=3'b010.
- R12: `mem_re_o` and `mem_we_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field of register-format instructions |
| dst_rd_o | output | 1 | Destination register comes from the rd field |
| src_imm_o | output | 1 | Second ALU operand is the sign-extended immediate |
| wb_mem_o | output | 1 | Write-back data comes from memory |
| rf_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| br_o | output | 1 | Conditional branch instruction |
| cls_o | output | 2 | Operation class: 00 memory, 01 compare, 10 register |
| alu_op_o | output | 3 | ALU operation code |

## Verification
The only internal state in this block is the output register. A wrong capture appears one cycle after the instruction is presented, as an enable or code that does not match the opcode sampled at the previous edge. A wrong class from the first stage surfaces in the same cycle as a wrong `alu_op_o`. For example, a branch whose ALU code reads as add, or a load whose code changes with the function field, reveals a class fault even when the enables look correct. Glitches on the enables between edges would break the hold checks made just before each edge.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int CLS_W = 2;
  localparam int ALU_W = 3;

  localparam logic [OP_W-1:0] OPC_REG = 6'd0;
  localparam logic [OP_W-1:0] OPC_BEQ = 6'd4;
  localparam logic [OP_W-1:0] OPC_LD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_ST  = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [CLS_W-1:0] CLS_MEM = 2'b00;
  localparam logic [CLS_W-1:0] CLS_CMP = 2'b01;
  localparam logic [CLS_W-1:0] CLS_REG = 2'b10;

  localparam logic [ALU_W-1:0] AC_AND = 3'b000;
  localparam logic [ALU_W-1:0] AC_OR  = 3'b001;
  localparam logic [ALU_W-1:0] AC_ADD = 3'b010;
  localparam logic [ALU_W-1:0] AC_SUB = 3'b110;
  localparam logic [ALU_W-1:0] AC_SLT = 3'b111;

  typedef struct packed {
    logic             dst_rd;
    logic             src_imm;
    logic             wb_mem;
    logic             rf_we;
    logic             mem_re;
    logic             mem_we;
    logic             br;
    logic [CLS_W-1:0] cls;
  } ctl_t;
endpackage

// File: rtl/scd_main_dec.sv
module scd_main_dec
  import scd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctl_t            ctl
);
  always_comb begin
    ctl     = '0;
    ctl.cls = CLS_MEM;
    unique case (op)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.cls    = CLS_REG;
      end
      OPC_LD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.rf_we   = 1'b1;
        ctl.mem_re  = 1'b1;
      end
      OPC_ST: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.br  = 1'b1;
        ctl.cls = CLS_CMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/scd_alu_ctl.sv
module scd_alu_ctl
  import scd_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic [FN_W-1:0]  fn,
  output logic [ALU_W-1:0] alu_op
);
  always_comb begin
    alu_op = AC_ADD;
    case (cls)
      CLS_CMP: alu_op = AC_SUB;
      CLS_REG: begin
        case (fn)
          FN_ADD:  alu_op = AC_ADD;
          FN_SUB:  alu_op = AC_SUB;
          FN_AND:  alu_op = AC_AND;
          FN_OR:   alu_op = AC_OR;
          FN_SLT:  alu_op = AC_SLT;
          default: alu_op = AC_ADD;
        endcase
      end
      default: alu_op = AC_ADD;
    endcase
  end
endmodule

// File: rtl/sc_ctl_decoder.sv
module sc_ctl_decoder
  import scd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             dst_rd_o,
  output logic             src_imm_o,
  output logic             wb_mem_o,
  output logic             rf_we_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic             br_o,
  output logic [CLS_W-1:0] cls_o,
  output logic [ALU_W-1:0] alu_op_o
);
  ctl_t             ctl_c;
  ctl_t             ctl_q;
  logic [ALU_W-1:0] alu_c;
  logic [ALU_W-1:0] alu_q;

  scd_main_dec u_main (
    .op  (op_i),
    .ctl (ctl_c)
  );

  scd_alu_ctl u_alu (
    .cls    (ctl_c.cls),
    .fn     (fn_i),
    .alu_op (alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      alu_q <= '0;
    end else begin
      ctl_q <= ctl_c;
      alu_q <= alu_c;
    end
  end

  assign dst_rd_o  = ctl_q.dst_rd;
  assign src_imm_o = ctl_q.src_imm;
  assign wb_mem_o  = ctl_q.wb_mem;
  assign rf_we_o   = ctl_q.rf_we;
  assign mem_re_o  = ctl_q.mem_re;
  assign mem_we_o  = ctl_q.mem_we;
  assign br_o      = ctl_q.br;
  assign cls_o     = ctl_q.cls;
  assign alu_op_o  = alu_q;
endmodule

// File: rtl/sc_ctl_decoder_chk.sv
module sc_ctl_decoder_chk
  import scd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_i,
  input logic [FN_W-1:0]  fn_i,
  input logic             dst_rd_o,
  input logic             src_imm_o,
  input logic             wb_mem_o,
  input logic             rf_we_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic             br_o,
  input logic [CLS_W-1:0] cls_o,
  input logic [ALU_W-1:0] alu_op_o
);
  logic known_op;
  assign known_op = (op_i == OPC_REG) || (op_i == OPC_LD) ||
                    (op_i == OPC_ST)  || (op_i == OPC_BEQ);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rf_we_o && !mem_re_o && !mem_we_o && !br_o && alu_op_o == '0));

  p_reg_fmt_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_REG) |=> (dst_rd_o && rf_we_o && !mem_re_o && !mem_we_o && cls_o == CLS_REG));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_LD) |=> (mem_re_o && wb_mem_o && rf_we_o && src_imm_o && alu_op_o == AC_ADD));

  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_ST) |=> (mem_we_o && !rf_we_o && alu_op_o == AC_ADD));

  p_branch_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_BEQ) |=> (br_o && !rf_we_o && alu_op_o == AC_SUB));

  p_funct_sub_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_REG && fn_i == FN_SUB) |=> (alu_op_o == AC_SUB));

  p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!known_op) |=> (!rf_we_o && !mem_re_o && !mem_we_o && !br_o));

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_re_o, mem_we_o}));
endmodule

bind sc_ctl_decoder sc_ctl_decoder_chk u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i),
  .dst_rd_o(dst_rd_o), .src_imm_o(src_imm_o), .wb_mem_o(wb_mem_o),
  .rf_we_o(rf_we_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
  .br_o(br_o), .cls_o(cls_o), .alu_op_o(alu_op_o)
);

// File: tb/sc_ctl_decoder_tb.sv
`timescale 1ns/1ps
module sc_ctl_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op_i = 6'd0;
  logic [5:0] fn_i = 6'd0;
  logic dst_rd_o, src_imm_o, wb_mem_o, rf_we_o, mem_re_o, mem_we_o, br_o;
  logic [1:0] cls_o;
  logic [2:0] alu_op_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sc_ctl_decoder u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i),
    .dst_rd_o(dst_rd_o), .src_imm_o(src_imm_o), .wb_mem_o(wb_mem_o),
    .rf_we_o(rf_we_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
    .br_o(br_o), .cls_o(cls_o), .alu_op_o(alu_op_o)
  );

  // packing: dst, src, wb, we, re, mwe, br, cls[1:0], alu[2:0]
  function automatic logic [11:0] vec(input logic d, s, w, we, re, mw, b,
                                      input logic [1:0] c, input logic [2:0] a);
    return {d, s, w, we, re, mw, b, c, a};
  endfunction

  function automatic logic [11:0] got();
    return {dst_rd_o, src_imm_o, wb_mem_o, rf_we_o, mem_re_o, mem_we_o, br_o, cls_o, alu_op_o};
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    total++;
    if (got() !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, got(), exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    op_i = op;
    fn_i = fn;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [11:0] exp_reg(input logic [2:0] a);
    return vec(1, 0, 0, 1, 0, 0, 0, 2'b10, a);
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    apply(6'd35, 6'h20);
    check("R1 reset with load opcode", '0);
    apply(6'd0, 6'h2A);
    check("R1 reset with register opcode", '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_rtype();
    apply(6'd0, 6'h20); check("R3 R9 add", exp_reg(3'b010));
    apply(6'd0, 6'h22); check("R9 sub", exp_reg(3'b110));
    apply(6'd0, 6'h24); check("R9 and", exp_reg(3'b000));
    apply(6'd0, 6'h25); check("R9 or", exp_reg(3'b001));
    apply(6'd0, 6'h2A); check("R9 slt", exp_reg(3'b111));
  endtask

  task automatic t_unknown_fn();
    apply(6'd0, 6'h3F); check("R10 funct 0x3F", exp_reg(3'b010));
    apply(6'd0, 6'h2B); check("R10 funct 0x2B", exp_reg(3'b010));
  endtask

  task automatic t_load();
    apply(6'd35, 6'h22); check("R4 R7 load funct sub", vec(0, 1, 1, 1, 1, 0, 0, 2'b00, 3'b010));
    apply(6'd35, 6'h25); check("R7 load funct or", vec(0, 1, 1, 1, 1, 0, 0, 2'b00, 3'b010));
  endtask

  task automatic t_store();
    apply(6'd43, 6'h2A); check("R5 R12 store", vec(0, 1, 0, 0, 0, 1, 0, 2'b00, 3'b010));
  endtask

  task automatic t_branch();
    apply(6'd4, 6'h24); check("R6 R8 beq funct and", vec(0, 0, 0, 0, 0, 0, 1, 2'b01, 3'b110));
    apply(6'd4, 6'h20); check("R8 beq funct add", vec(0, 0, 0, 0, 0, 0, 1, 2'b01, 3'b110));
  endtask

  task automatic t_unknown_op();
    apply(6'd2, 6'h22);  check("R11 opcode 2", vec(0, 0, 0, 0, 0, 0, 0, 2'b00, 3'b010));
    apply(6'd63, 6'h2A); check("R11 opcode 63", vec(0, 0, 0, 0, 0, 0, 0, 2'b00, 3'b010));
    apply(6'd36, 6'h00); check("R11 opcode 36", vec(0, 0, 0, 0, 0, 0, 0, 2'b00, 3'b010));
  endtask

  task automatic t_latency();
    apply(6'd35, 6'h20);
    @(negedge clk);
    op_i = 6'd43;
    #1;
    check("R2 hold before edge", vec(0, 1, 1, 1, 1, 0, 0, 2'b00, 3'b010));
    @(posedge clk);
    #2;
    check("R2 update after edge", vec(0, 1, 0, 0, 0, 1, 0, 2'b00, 3'b010));
  endtask

  initial begin
    #(8 * 5000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rtype();
    t_unknown_fn();
    t_load();
    t_store();
    t_branch();
    t_unknown_op();
    t_latency();
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule